// File: doc/BRIEF.md
# Clause-22 MDIO Management Access Engine

This block lets a host reach the management registers of Ethernet PHYs through one 32-bit access word. The host writes the word with the request flag set; the engine then produces a complete clause-22 management frame on the MDC clock and MDIO data pins. It releases the data line whenever the PHY has to drive it, and it clears the request flag when the last bit has gone by. The host polls the word until the flag reads 0. After a read, the low 16 bits of the word hold the value that the PHY returned.

MDC is derived from the system clock. Its half period is the parameter `MDC_HALF` system clocks. The number of preamble ones is the parameter `PREAMBLE_BITS`. A frame lasts `(PREAMBLE_BITS + 32) * 2 * MDC_HALF` clocks.

Top module: `mdio_access_engine`

## Requirements
- R1: After reset, `acc_rdata` reads 0, and `mdc`, `mdio_o` and `mdio_oe` are low.
- R2: A write of the access word with bit 31 set, made while bit 31 reads 0, starts a frame. Bit 31 reads 1 from the clock edge that accepts the write until the frame ends, which is exactly `(PREAMBLE_BITS+32)*2*MDC_HALF` clocks. It then reads 0.
- R3: Layout of the access word: bit 31 is the request/busy flag, bit 30 the direction (1 write, 0 read), bits 25:21 the PHY address, bits 20:16 the register address and bits 15:0 the data. Bits 29:26 always read 0.
- R4: While idle, MDC is low. During a frame it has a period of `2*MDC_HALF` clocks. It first rises `MDC_HALF` clocks after the accepting edge, and a frame contains exactly `PREAMBLE_BITS+32` rising edges.
- R5: Each frame is sent MSB first and consists of `PREAMBLE_BITS` ones, then start bits 01, then opcode 01 (write) or 10 (read), the 5-bit PHY address, the 5-bit register address, a turnaround, and 16 data bits. A write uses the turnaround 10 and carries the word's data.
- R6: `mdio_o` changes only at the accepting edge, at falling MDC edges, and at the end of the frame. It is stable across every rising MDC edge.
- R7: During a write, `mdio_oe` is high for the whole frame. During a read, it is high only through the register address and low for the turnaround and the data bits. When idle it is low. `mdio_o` is 0 whenever `mdio_oe` is 0.
- R8: During a read, `mdio_i` is sampled at each rising MDC edge. When the frame ends, bits 15:0 hold the last 16 samples, with the first sample in bit 15.
- R9: A write to the access word while bit 31 reads 1 is ignored. It starts no new frame and does not change any field.
- R10: A write with bit 31 clear while the engine is idle updates the fields and starts no frame.
- R11: Writing 0xC0A09000 produces a frame that writes 0x9000 to register 0 of PHY address 5. Afterwards the word reads 0x40A09000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_wr | input | 1 | Write strobe for the access word |
| acc_wdata | input | 32 | Access word write value |
| acc_rdata | output | 32 | Access word read value |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
Write frames are run with all-ones and all-zeros data and with the extreme addresses 0 and 31, so that a dropped, swapped or shifted bit in any header field shows up in the decoded frame. Read frames use PHY patterns whose single set bit sits at either end (0x0001, 0x8000) as well as a mixed pattern, which separates off-by-one sampling and bit-order errors. A write issued mid-frame tests that it is ignored, and a write with the request flag clear tests that only the fields change. A behavioural model runs alongside and compares MDC, data, enable and the word on every clock.

// File: rtl/mdio_eng_pkg.sv
package mdio_eng_pkg;

   localparam int ACC_W          = 32;
   localparam int HDR_W          = 32;
   localparam int DATA_W         = 16;
   localparam int ADDR_W         = 5;
   // start(2) + opcode(2) + phy(5) + reg(5): bits the master drives on a read
   localparam int HDR_DRIVE_BITS = 14;

   localparam logic [1:0] SOF_CODE = 2'b01;
   localparam logic [1:0] OP_WR    = 2'b01;
   localparam logic [1:0] OP_RD    = 2'b10;
   localparam logic [1:0] TA_WR    = 2'b10;

   typedef struct packed {
      logic              req;
      logic              wr;
      logic [3:0]        rsv;
      logic [ADDR_W-1:0] phy;
      logic [ADDR_W-1:0] regad;
      logic [DATA_W-1:0] data;
   } acc_word_t;

   function automatic logic [HDR_W-1:0] pack_frame(input logic              wr,
                                                   input logic [ADDR_W-1:0] phy,
                                                   input logic [ADDR_W-1:0] regad,
                                                   input logic [DATA_W-1:0] data);
      logic [1:0] op;
      logic [1:0] ta;
      logic [DATA_W-1:0] dv;
      op = wr ? OP_WR : OP_RD;
      ta = wr ? TA_WR : 2'b00;
      dv = wr ? data : '0;
      return {SOF_CODE, op, phy, regad, ta, dv};
   endfunction

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
   parameter int MDC_HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise_stb,
   output logic fall_stb
);

   localparam int CW = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;

   logic tick;

   generate
      if (MDC_HALF == 1) begin : g_toggle
         assign tick = run;
      end else begin : g_count
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (!run) begin
               cnt <= '0;
            end else if (cnt == CW'(MDC_HALF - 1)) begin
               cnt <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
         assign tick = run && (cnt == CW'(MDC_HALF - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mdc <= 1'b0;
      end else if (!run) begin
         mdc <= 1'b0;
      end else if (tick) begin
         mdc <= ~mdc;
      end
   end

   assign rise_stb = tick & ~mdc;
   assign fall_stb = tick & mdc;

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
   import mdio_eng_pkg::*;
#(
   parameter int PREAMBLE_BITS = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              start_wr,
   input  logic [HDR_W-1:0]  start_hdr,
   input  logic              rise_stb,
   input  logic              fall_stb,
   input  logic              mdio_i,
   output logic              busy,
   output logic              mdio_o,
   output logic              mdio_oe,
   output logic [DATA_W-1:0] rx_word,
   output logic              done
);

   localparam int FRAME_BITS = PREAMBLE_BITS + HDR_W;
   localparam int IW         = $clog2(FRAME_BITS);
   localparam int DRIVE_END  = PREAMBLE_BITS + HDR_DRIVE_BITS;

   logic [IW-1:0]    idx;
   logic [IW-1:0]    nxt;
   logic [HDR_W-1:0] hdr_q;
   logic             wr_q;
   logic             drive_nxt;
   logic             bit_nxt;
   logic [4:0]       pos;
   logic             last_bit;

   always_comb begin
      nxt       = idx + 1'b1;
      drive_nxt = wr_q || (int'(nxt) < DRIVE_END);
      pos       = 5'(FRAME_BITS - 1 - int'(nxt));
      bit_nxt   = (int'(nxt) < PREAMBLE_BITS) ? 1'b1 : hdr_q[pos];
      last_bit  = (idx == IW'(FRAME_BITS - 1));
   end

   assign done = busy && fall_stb && last_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         idx     <= '0;
         hdr_q   <= '0;
         wr_q    <= 1'b0;
         mdio_o  <= 1'b0;
         mdio_oe <= 1'b0;
         rx_word <= '0;
      end else if (start && !busy) begin
         busy    <= 1'b1;
         idx     <= '0;
         hdr_q   <= start_hdr;
         wr_q    <= start_wr;
         mdio_oe <= 1'b1;
         mdio_o  <= 1'b1;
      end else if (busy) begin
         if (rise_stb) begin
            rx_word <= {rx_word[DATA_W-2:0], mdio_i};
         end
         if (fall_stb) begin
            if (last_bit) begin
               busy    <= 1'b0;
               idx     <= '0;
               mdio_oe <= 1'b0;
               mdio_o  <= 1'b0;
            end else begin
               idx     <= nxt;
               mdio_oe <= drive_nxt;
               mdio_o  <= drive_nxt & bit_nxt;
            end
         end
      end
   end

endmodule

// File: rtl/mdio_access_engine.sv
module mdio_access_engine
   import mdio_eng_pkg::*;
#(
   parameter int MDC_HALF      = 2,
   parameter int PREAMBLE_BITS = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_wr,
   input  logic [ACC_W-1:0]  acc_wdata,
   output logic [ACC_W-1:0]  acc_rdata,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i
);

   generate
      if (MDC_HALF < 1) begin : g_bad_div
         $error("MDC_HALF must be at least 1");
      end
      if (PREAMBLE_BITS < 1 || PREAMBLE_BITS > 32) begin : g_bad_pre
         $error("PREAMBLE_BITS must lie in 1..32");
      end
   endgenerate

   acc_word_t          wv;
   logic               busy;
   logic               accept;
   logic               start;
   logic               done;
   logic               rise_stb;
   logic               fall_stb;
   logic [DATA_W-1:0]  rx_word;
   logic [HDR_W-1:0]   hdr;

   logic               f_wr;
   logic [ADDR_W-1:0]  f_phy;
   logic [ADDR_W-1:0]  f_reg;
   logic [DATA_W-1:0]  f_data;
   logic               unused_rsv;

   assign wv         = acc_word_t'(acc_wdata);
   assign unused_rsv = ^wv.rsv;
   assign accept     = acc_wr && !busy;
   assign start      = accept && wv.req;
   assign hdr        = pack_frame(wv.wr, wv.phy, wv.regad, wv.data);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         f_wr   <= 1'b0;
         f_phy  <= '0;
         f_reg  <= '0;
         f_data <= '0;
      end else if (accept) begin
         f_wr   <= wv.wr;
         f_phy  <= wv.phy;
         f_reg  <= wv.regad;
         f_data <= wv.data;
      end else if (done && !f_wr) begin
         f_data <= rx_word;
      end
   end

   mdio_clk_div #(.MDC_HALF(MDC_HALF)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (busy),
      .mdc      (mdc),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb)
   );

   mdio_frame_seq #(.PREAMBLE_BITS(PREAMBLE_BITS)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .start_wr  (wv.wr),
      .start_hdr (hdr),
      .rise_stb  (rise_stb),
      .fall_stb  (fall_stb),
      .mdio_i    (mdio_i),
      .busy      (busy),
      .mdio_o    (mdio_o),
      .mdio_oe   (mdio_oe),
      .rx_word   (rx_word),
      .done      (done)
   );

   assign acc_rdata = {busy, f_wr, 4'b0000, f_phy, f_reg, f_data};

endmodule

// File: rtl/mdio_eng_checks.sv
module mdio_eng_checks (
   input logic        clk,
   input logic        rst_n,
   input logic        acc_wr,
   input logic [31:0] acc_rdata,
   input logic        mdc,
   input logic        mdio_o,
   input logic        mdio_oe
);

   // R4: no management clock while idle
   a_r4_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_rdata[31] |-> !mdc);

   // R7: line released while idle
   a_r7_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_rdata[31] |-> !mdio_oe);

   // R7: data is 0 whenever the line is released
   a_r7_quiet_when_released: assert property (@(posedge clk) disable iff (!rst_n)
      !mdio_oe |-> !mdio_o);

   // R7: a write frame drives the line throughout
   a_r7_write_drives: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_rdata[31] && acc_rdata[30]) |-> mdio_oe);

   // R6: data moves only with a falling clock mid-frame
   a_r6_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_rdata[31] && $past(acc_rdata[31]) && !$fell(mdc)) |-> $stable(mdio_o));

   // R9: fields frozen while a frame runs, whatever is written
   a_r9_fields_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_rdata[31] && $past(acc_rdata[31])) |-> $stable(acc_rdata[30:16]));

   // R3: reserved bits read zero
   a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      acc_rdata[29:26] == 4'b0000);

   // R2: a frame cannot end before MDC has run
   a_r2_no_instant_end: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(acc_rdata[31]) |=> acc_rdata[31]);

endmodule

bind mdio_access_engine mdio_eng_checks u_checks (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_wr    (acc_wr),
   .acc_rdata (acc_rdata),
   .mdc       (mdc),
   .mdio_o    (mdio_o),
   .mdio_oe   (mdio_oe)
);

// File: tb/tb_mdio_access_engine.sv
`timescale 1ns/1ps
module tb_mdio_access_engine;

   localparam int H     = 2;
   localparam int PRE   = 32;
   localparam int FRAME = PRE + 32;
   localparam int LEN   = FRAME * 2 * H;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_wr = 1'b0;
   logic [31:0] acc_wdata = '0;
   logic [31:0] acc_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b1;

   int errs = 0;
   int checks = 0;

   always #4 clk = ~clk;

   mdio_access_engine #(.MDC_HALF(H), .PREAMBLE_BITS(PRE)) dut (
      .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_wdata(acc_wdata),
      .acc_rdata(acc_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
      .mdio_i(mdio_i));

   // ---------------- behavioural reference ----------------
   bit          m_busy = 0;
   int          m_e = 0;
   bit          m_dir = 0;
   bit [4:0]    m_phy = 0;
   bit [4:0]    m_reg = 0;
   bit [15:0]   m_data = 0;
   bit [15:0]   m_rx = 0;
   bit [15:0]   phy_word = 16'h0;

   function automatic bit frame_bit(bit wr, bit [4:0] phy, bit [4:0] rg, bit [15:0] d, int i);
      bit [31:0] h;
      if (i < PRE) return 1'b1;
      h = {2'b01, (wr ? 2'b01 : 2'b10), phy, rg, (wr ? 2'b10 : 2'b00), (wr ? d : 16'h0)};
      return h[31 - (i - PRE)];
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_e = 0; m_dir = 0; m_phy = 0; m_reg = 0; m_data = 0; m_rx = 0;
      end else if (m_busy) begin
         m_e++;
         if (m_e % (2*H) == H) m_rx = {m_rx[14:0], mdio_i};
         if (m_e == LEN) begin
            m_busy = 0;
            if (!m_dir) m_data = m_rx;
         end
      end else if (acc_wr) begin
         m_dir = acc_wdata[30]; m_phy = acc_wdata[25:21];
         m_reg = acc_wdata[20:16]; m_data = acc_wdata[15:0];
         if (acc_wdata[31]) begin m_busy = 1; m_e = 0; end
      end
   end

   // PHY side: drives turnaround low bit and data on reads
   always @(negedge clk) begin
      int idx, k;
      idx = m_e / (2*H);
      k = idx - PRE;
      if (m_busy && !m_dir && k == 15) mdio_i <= 1'b0;
      else if (m_busy && !m_dir && k >= 16 && k <= 31) mdio_i <= phy_word[31 - k];
      else mdio_i <= 1'b1;
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         int idx;
         bit e_mdc, e_oe, e_o;
         idx   = m_e / (2*H);
         e_mdc = m_busy && ((m_e % (2*H)) >= H);
         e_oe  = m_busy && (m_dir || idx < PRE + 14);
         e_o   = e_oe && frame_bit(m_dir, m_phy, m_reg, m_data, idx);
         chk("R4 mdc", 32'(mdc), 32'(e_mdc));
         chk("R7 mdio_oe", 32'(mdio_oe), 32'(e_oe));
         chk("R5 mdio_o", 32'(mdio_o), 32'(e_o));
         chk("R2/R3 acc_rdata", acc_rdata, {m_busy, m_dir, 4'b0, m_phy, m_reg, m_data});
      end
   end

   // frame decode from the pins
   bit cap_o[$];
   bit cap_oe[$];
   always @(posedge mdc) begin
      cap_o.push_back(mdio_o);
      cap_oe.push_back(mdio_oe);
   end

   task automatic do_write(logic [31:0] v);
      @(negedge clk); acc_wr = 1'b1; acc_wdata = v;
      @(negedge clk); acc_wr = 1'b0;
   endtask

   task automatic run_frame(logic [31:0] v, output int busy_cycles);
      cap_o.delete(); cap_oe.delete();
      do_write(v);
      busy_cycles = 0;
      while (acc_rdata[31] && busy_cycles < 4*LEN) begin
         busy_cycles++;
         @(negedge clk);
      end
   endtask

   task automatic check_frame(string req, logic [31:0] v);
      int drv;
      int nrel;
      chk({req, " rising edges"}, 32'(cap_o.size()), 32'(FRAME));
      if (cap_o.size() != FRAME) return;
      drv = v[30] ? FRAME : PRE + 14;
      nrel = 0;
      for (int i = 0; i < FRAME; i++) if (!cap_oe[i]) nrel++;
      chk({req, " released bits"}, 32'(nrel), 32'(FRAME - drv));
      for (int i = 0; i < drv; i++)
         chk({req, " frame bit"}, 32'(cap_o[i]),
             32'(frame_bit(v[30], v[25:21], v[20:16], v[15:0], i)));
   endtask

   initial begin
      int n;
      repeat (3) @(negedge clk);
      // R1
      chk("R1 rdata", acc_rdata, 32'h0);
      chk("R1 pins", {29'h0, mdc, mdio_o, mdio_oe}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 / R2 / R5
      run_frame(32'hC0A0_9000, n);
      chk("R2 busy length", 32'(n), 32'(LEN));
      check_frame("R11", 32'hC0A0_9000);
      chk("R11 readback", acc_rdata, 32'h40A0_9000);

      // R5 extremes, R3 reserved bits ignored
      run_frame(32'hFFFF_FFFF, n);
      check_frame("R5 ones", 32'hFFFF_FFFF);
      chk("R3 reserved", acc_rdata, 32'h43FF_FFFF);
      run_frame(32'hC000_0000, n);
      check_frame("R5 zeros", 32'hC000_0000);

      // R8 reads
      phy_word = 16'hA5C3;
      run_frame(32'h83F1_0000, n);
      check_frame("R7 read", 32'h83F1_0000);
      chk("R8 read data", acc_rdata, 32'h03F1_A5C3);
      phy_word = 16'h0001;
      run_frame(32'h8020_FFFF, n);
      chk("R8 lsb", acc_rdata, 32'h0020_0001);
      phy_word = 16'h8000;
      run_frame(32'h8000_1234, n);
      chk("R8 msb", acc_rdata, 32'h0000_8000);

      // R9: write while busy is ignored
      cap_o.delete(); cap_oe.delete();
      do_write(32'hC0A0_5555);
      repeat (40) @(negedge clk);
      do_write(32'hC3FF_AAAA);
      n = 0;
      while (acc_rdata[31] && n < 4*LEN) begin n++; @(negedge clk); end
      chk("R9 fields", acc_rdata, 32'h40A0_5555);
      check_frame("R9 frame", 32'hC0A0_5555);
      repeat (12) @(negedge clk);
      chk("R9 no restart", {30'h0, acc_rdata[31], mdc}, 32'h0);

      // R10: request clear only updates fields
      do_write(32'h4123_4567);
      repeat (20) @(negedge clk);
      chk("R10 fields", acc_rdata, 32'h4123_4567);
      chk("R10 no clock", {31'h0, mdc}, 32'h0);

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errs++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule